// File: doc/BRIEF.md
# Interrupt Group Modifier Bank

This block holds one group-modifier bit for every interrupt of an extended shared-interrupt range and serves them as a bank of 32-bit memory-mapped words. Each word covers 32 consecutive interrupts. Interrupt IDs in the range start at 4096, and interrupt `m` sits in word `(m-4096)/32` at bit `(m-4096) % 32`. Word `n` is at byte address `0x3400 + 4*n`. Every access carries a secure or non-secure attribute. Each bit is filtered on its own: access depends on the security state of its own interrupt, on whether that interrupt exists, on whether its word is implemented, and on whether routing is enabled for its security state.

The group-status bits come from a companion register outside the block and arrive on an input vector. Each filtered modifier bit is joined with its group-status bit to give a 2-bit group code per interrupt. The interrupt controller around the block uses these codes for prioritisation and delivery.

Requests use a valid/ready pair. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is pending or the pending response is being taken in that cycle. Each accepted request produces exactly one response in the following cycle. That response stays valid, with stable data, until `rsp_ready` is high. Back-pressure on the response side therefore stalls new requests.

Top module: `grpmod_bank`

## Requirements
- R1: After reset every stored modifier bit is 0, no response is pending, and each group code is 0 (secure group 0) where the status bit is 0 and 1 (non-secure group 1) where it is 1.
- R2: Word `n` is at byte address 0x3400+4*n. Interrupt `m` maps to word (m-4096)/32 at bit (m-4096)%32. Its code is `grp_code[2*(m-4096) +: 2]`, and its status bit is `grp_status[m-4096]`.
- R3: Each accepted request gives one response in the next cycle. The response is held, with stable data, while `rsp_ready` is low, and no request is accepted during that time.
- R4: A read returns the filtered word in `rsp_rdata`. A write returns `rsp_rdata` = 0 and, in the next cycle, sets every permitted bit to the written value. All other bits keep their stored value.
- R5: While `ext_present` is 0, every read returns zero, writes change nothing, and no group code is 2.
- R6: Only words 0 to min(`ext_range`, MAX_REGS-1) are implemented. Unimplemented words, addresses outside the window, and addresses not word-aligned read zero and ignore writes.
- R7: A bit whose `impl_mask` bit is 0 reads zero and ignores writes.
- R8: While `sec_disable` is 0, a non-secure access reads zero from bits whose status bit is 0 (secure interrupts) and leaves them unchanged. The other bits in the same write are still updated.
- R9: A secure access, or any access while `sec_disable` is 1, reads and writes every live bit.
- R10: Routing for an interrupt follows `route_s` when its status bit is 0 and `route_ns` when it is 1. While routing is disabled the bit reads zero, a write to it is not stored, and it decodes as modifier 0.
- R11: The group code is taken from {filtered modifier, status}: 00 gives 0 (secure group 0), 01 and 11 give 1 (non-secure group 1), and 10 gives 2 (secure group 1). Code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| ext_present | input | 1 | Extended range present |
| ext_range | input | 5 | Highest implemented word number |
| sec_disable | input | 1 | 1 = single security state |
| route_s | input | 1 | Routing enabled for secure interrupts |
| route_ns | input | 1 | Routing enabled for non-secure interrupts |
| impl_mask | input | 32*MAX_REGS | 1 = interrupt implemented |
| grp_status | input | 32*MAX_REGS | Group-status bit per interrupt |
| grp_code | output | 64*MAX_REGS | 2-bit group code per interrupt |

## Verification
A response is due one rising edge after its request is accepted. The bench checks it at the falling edge that follows. Stored bits change on that same edge, so the group codes are compared against the model at that falling edge too. Group codes are combinational in the configuration inputs. After a configuration change, the bench rechecks them one time step after driving the change and before any later edge. During back-pressure the held response is checked at several falling edges in a row.

// File: rtl/grpmod_pkg.sv
package grpmod_pkg;
  localparam int unsigned WORD_BITS = 32;

  typedef enum logic [1:0] {
    GRP_G0S  = 2'd0,
    GRP_G1NS = 2'd1,
    GRP_G1S  = 2'd2
  } grp_code_e;

  // {modifier, status} -> group code; 11 folds onto non-secure group 1
  function automatic logic [1:0] grp_decode(input logic mod_b, input logic stat_b);
    logic [1:0] code;
    unique case ({mod_b, stat_b})
      2'b00:   code = GRP_G0S;
      2'b10:   code = GRP_G1S;
      default: code = GRP_G1NS;
    endcase
    return code;
  endfunction
endpackage

// File: rtl/grpmod_addr_dec.sv
module grpmod_addr_dec #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h3400,
  parameter int unsigned MAX_REGS  = 4,
  parameter int unsigned IDX_W     = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                ext_present,
  input  logic [4:0]          ext_range,
  output logic                hit,
  output logic [IDX_W-1:0]    idx,
  output logic [MAX_REGS-1:0] reg_active
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * MAX_REGS);

  logic [ADDR_W-1:0] offset;
  logic              in_win;

  for (genvar r = 0; r < MAX_REGS; r++) begin : g_active
    assign reg_active[r] = ext_present && (r <= int'(ext_range));
  end

  assign offset = addr - BASE;
  assign in_win = (addr >= BASE) && (offset < SPAN) && (addr[1:0] == 2'b00);
  assign idx    = offset[IDX_W+1:2];
  assign hit    = in_win && reg_active[idx];
endmodule

// File: rtl/grpmod_bit_policy.sv
module grpmod_bit_policy #(
  parameter int unsigned MAX_REGS = 4,
  parameter int unsigned NUM_INT  = MAX_REGS * 32
) (
  input  logic [MAX_REGS-1:0] reg_active,
  input  logic [NUM_INT-1:0]  impl_mask,
  input  logic [NUM_INT-1:0]  grp_status,
  input  logic                route_s,
  input  logic                route_ns,
  input  logic                sec_disable,
  input  logic                req_secure,
  output logic [NUM_INT-1:0]  live,
  output logic [NUM_INT-1:0]  vis
);
  for (genvar i = 0; i < NUM_INT; i++) begin : g_bit
    logic routed;
    // a status of 0 marks the interrupt as secure
    assign routed  = grp_status[i] ? route_ns : route_s;
    assign live[i] = reg_active[i / 32] && impl_mask[i] && routed;
    assign vis[i]  = live[i] && (req_secure || sec_disable || grp_status[i]);
  end
endmodule

// File: rtl/grpmod_store.sv
module grpmod_store #(
  parameter int unsigned MAX_REGS = 4,
  parameter int unsigned IDX_W    = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         idx,
  input  logic [31:0]              wdata,
  input  logic [31:0]              wmask,
  output logic [MAX_REGS*32-1:0]   bits
);
  for (genvar r = 0; r < MAX_REGS; r++) begin : g_row
    logic [31:0] row_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (wr_en && (int'(idx) == r)) begin
        row_q <= (row_q & ~wmask) | (wdata & wmask);
      end
    end
    assign bits[r*32 +: 32] = row_q;
  end
endmodule

// File: rtl/grpmod_bank.sv
module grpmod_bank #(
  parameter int unsigned MAX_REGS  = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h3400
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic                      req_secure,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [31:0]               req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [31:0]               rsp_rdata,
  input  logic                      ext_present,
  input  logic [4:0]                ext_range,
  input  logic                      sec_disable,
  input  logic                      route_s,
  input  logic                      route_ns,
  input  logic [MAX_REGS*32-1:0]    impl_mask,
  input  logic [MAX_REGS*32-1:0]    grp_status,
  output logic [MAX_REGS*64-1:0]    grp_code
);
  import grpmod_pkg::*;

  localparam int unsigned NUM_INT = MAX_REGS * 32;
  localparam int unsigned IDX_W   = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1;

  logic                hit;
  logic [IDX_W-1:0]    idx;
  logic [MAX_REGS-1:0] reg_active;
  logic [NUM_INT-1:0]  live, vis, stored, eff;
  logic [31:0]         eff_row, vis_row, rd_word;
  logic                req_fire, wr_en;

  grpmod_addr_dec #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MAX_REGS(MAX_REGS), .IDX_W(IDX_W)
  ) u_dec (
    .addr(req_addr), .ext_present(ext_present), .ext_range(ext_range),
    .hit(hit), .idx(idx), .reg_active(reg_active)
  );

  grpmod_bit_policy #(.MAX_REGS(MAX_REGS), .NUM_INT(NUM_INT)) u_policy (
    .reg_active(reg_active), .impl_mask(impl_mask), .grp_status(grp_status),
    .route_s(route_s), .route_ns(route_ns), .sec_disable(sec_disable),
    .req_secure(req_secure), .live(live), .vis(vis)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign wr_en     = req_fire && req_write && hit;

  assign eff     = stored & live;
  assign eff_row = eff[{idx, 5'd0} +: 32];
  assign vis_row = vis[{idx, 5'd0} +: 32];
  assign rd_word = hit ? (eff_row & vis_row) : 32'd0;

  grpmod_store #(.MAX_REGS(MAX_REGS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx),
    .wdata(req_wdata), .wmask(vis_row), .bits(stored)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? 32'd0 : rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_INT; i++) begin : g_code
    assign grp_code[2*i +: 2] = grp_decode(eff[i], grp_status[i]);
  end
endmodule

// File: rtl/grpmod_bank_chk.sv
module grpmod_bank_chk #(
  parameter int unsigned MAX_REGS  = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h3400
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_write,
  input logic                   req_secure,
  input logic [ADDR_W-1:0]      req_addr,
  input logic [31:0]            req_wdata,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [31:0]            rsp_rdata,
  input logic                   ext_present,
  input logic [4:0]             ext_range,
  input logic                   sec_disable,
  input logic                   route_s,
  input logic                   route_ns,
  input logic [MAX_REGS*32-1:0] impl_mask,
  input logic [MAX_REGS*32-1:0] grp_status,
  input logic [MAX_REGS*64-1:0] grp_code
);
  logic any_g1s, any_bad;
  always_comb begin
    any_g1s = 1'b0;
    any_bad = 1'b0;
    for (int i = 0; i < MAX_REGS * 32; i++) begin
      if (grp_code[2*i +: 2] == 2'd2) any_g1s = 1'b1;
      if (grp_code[2*i +: 2] == 2'd3) any_bad = 1'b1;
    end
  end

  assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
  assert_rsp_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  assert_write_rdata_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> rsp_rdata == 32'd0);
  assert_misaligned_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_addr[1:0] != 2'b00) |=> rsp_rdata == 32'd0);
  assert_absent_no_g1s_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_present |-> !any_g1s);
  assert_code_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !any_bad);
endmodule

bind grpmod_bank grpmod_bank_chk #(
  .MAX_REGS(MAX_REGS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (.*);

// File: tb/grpmod_bank_bench.sv
`timescale 1ns/1ps
module grpmod_bank_bench;
  localparam int MR = 4;
  localparam int NI = MR * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 0, req_write = 0, req_secure = 0;
  logic [15:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_ready = 1;
  logic          req_ready, rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          ext_present = 1, sec_disable = 0, route_s = 1, route_ns = 1;
  logic [4:0]    ext_range = 5'd3;
  logic [NI-1:0] impl_mask = '1, grp_status = '0;
  logic [2*NI-1:0] grp_code;

  grpmod_bank #(.MAX_REGS(MR)) u_grpmod_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_secure(req_secure), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .ext_present(ext_present), .ext_range(ext_range),
    .sec_disable(sec_disable), .route_s(route_s), .route_ns(route_ns),
    .impl_mask(impl_mask), .grp_status(grp_status), .grp_code(grp_code)
  );

  bit ref_q [NI];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  function automatic bit reg_on(int r);
    return ext_present && (r <= int'(ext_range)) && (r < MR);
  endfunction
  function automatic bit live_b(int i);
    return reg_on(i / 32) && impl_mask[i] && (grp_status[i] ? route_ns : route_s);
  endfunction
  function automatic bit vis_b(int i, bit sec);
    return live_b(i) && (sec || sec_disable || grp_status[i]);
  endfunction
  function automatic int addr_reg(logic [15:0] a);
    int r;
    if (a[1:0] != 2'b00 || a < 16'h3400 || a >= 16'h3400 + 4 * MR) return -1;
    r = (int'(a) - 'h3400) / 4;
    return reg_on(r) ? r : -1;
  endfunction
  function automatic logic [1:0] exp_code(int i);
    bit m = ref_q[i] && live_b(i);
    if (grp_status[i]) return 2'd1;
    return m ? 2'd2 : 2'd0;
  endfunction

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic check_codes(string rq);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < NI; i++)
      if (grp_code[2*i +: 2] !== exp_code(i)) begin
        bad++;
        if (first < 0) first = i;
      end
    chk(rq, $sformatf("group codes mismatching (first index %0d)", first), bad, 0);
  endtask

  task automatic xact(bit wr, bit sec, logic [15:0] a, logic [31:0] wd, string rq);
    int r = addr_reg(a);
    logic [31:0] e = '0;
    if (r >= 0 && !wr)
      for (int b = 0; b < 32; b++) e[b] = ref_q[r*32+b] && vis_b(r*32+b, sec);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_secure = sec; req_addr = a; req_wdata = wd;
    @(posedge clk);
    if (wr && r >= 0)
      for (int b = 0; b < 32; b++)
        if (vis_b(r*32+b, sec)) ref_q[r*32+b] = wd[b];
    @(negedge clk);
    req_valid = 0;
    chk(rq, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(rq, "rsp_rdata", rsp_rdata, e);
    check_codes(rq);
  endtask

  task automatic rand_cfg();
    @(negedge clk);
    ext_present = ($urandom % 10) != 0;
    ext_range   = 5'($urandom % 6);
    sec_disable = $urandom % 2;
    route_s     = ($urandom % 5) != 0;
    route_ns    = ($urandom % 5) != 0;
    for (int i = 0; i < NI; i++) begin
      impl_mask[i]  = ($urandom % 10) != 0;
      grp_status[i] = $urandom % 2;
    end
    #1 check_codes("R10/R11 cfg");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NI; i++) grp_status[i] = $urandom % 2;
    grp_status[45] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    check_codes("R1");
    xact(0, 1, 16'h3400, 0, "R1 read word0");

    // R2/R11: interrupt 4141 -> word 1 bit 13, code index 45
    xact(1, 1, 16'h3404, 32'h1 << 13, "R2 write");
    chk("R2", "code of 4141", {30'd0, grp_code[90 +: 2]}, 32'd2);
    @(negedge clk); grp_status[45] = 1'b1;
    #1 chk("R11", "mod1 status1 code", {30'd0, grp_code[90 +: 2]}, 32'd1);
    @(negedge clk); grp_status[45] = 1'b0;

    xact(1, 1, 16'h3404, 32'hFFFF_FFFF, "R9 secure write");
    xact(0, 1, 16'h3404, 0, "R9 secure read");
    xact(1, 0, 16'h3404, 32'h0, "R8 ns write");
    xact(0, 0, 16'h3404, 0, "R8 ns read");
    xact(0, 1, 16'h3404, 0, "R8 secure bits kept");
    @(negedge clk); sec_disable = 1;
    xact(1, 0, 16'h3408, 32'hA5A5_5A5A, "R9 sd write");
    xact(0, 0, 16'h3408, 0, "R9 sd read");
    @(negedge clk); sec_disable = 0;

    xact(1, 1, 16'h3402, 32'hFFFF_FFFF, "R6 misaligned write");
    xact(0, 1, 16'h3402, 0, "R6 misaligned read");
    xact(0, 1, 16'h3410, 0, "R6 out of window");
    xact(0, 1, 16'h33FC, 0, "R6 below window");
    @(negedge clk); ext_range = 5'd1;
    xact(1, 1, 16'h3408, 32'hFFFF_FFFF, "R6 unimpl write");
    xact(0, 1, 16'h3408, 0, "R6 unimpl read");
    @(negedge clk); ext_range = 5'd3;
    xact(0, 1, 16'h3408, 0, "R6 word restored");

    @(negedge clk); ext_present = 0;
    xact(1, 1, 16'h3400, 32'hFFFF_FFFF, "R5 absent write");
    xact(0, 1, 16'h3404, 0, "R5 absent read");
    @(negedge clk); ext_present = 1;
    xact(0, 1, 16'h3400, 0, "R5 nothing stored");

    @(negedge clk); impl_mask[3] = 0;
    xact(1, 1, 16'h3400, 32'hFFFF_FFFF, "R7 write");
    @(negedge clk); impl_mask[3] = 1;
    xact(0, 1, 16'h3400, 0, "R7 bit3 unchanged");

    @(negedge clk); route_s = 0;
    #1 check_codes("R10 route off");
    xact(1, 1, 16'h340C, 32'hFFFF_FFFF, "R10 write");
    xact(0, 1, 16'h340C, 0, "R10 read");
    @(negedge clk); route_s = 1;
    xact(0, 1, 16'h340C, 0, "R10 not stored");

    // R3 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_secure = 1; req_addr = 16'h3404;
    @(negedge clk);
    req_valid = 0;
    held = rsp_rdata;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R3", "held rsp_valid", {31'd0, rsp_valid}, 32'd1);
      chk("R3", "req_ready while stalled", {31'd0, req_ready}, 32'd0);
      chk("R3", "held rdata", rsp_rdata, held);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk("R3", "rsp drained", {31'd0, rsp_valid}, 32'd0);

    for (int t = 0; t < 400; t++) begin
      logic [15:0] a;
      if ($urandom % 7 == 0) rand_cfg();
      a = 16'h3400 + 16'(4 * ($urandom % 6));
      if ($urandom % 10 == 0) a = a + 16'($urandom % 4);
      if ($urandom % 20 == 0) a = 16'($urandom);
      xact($urandom % 2, $urandom % 2, a, $urandom, "R4/R8/R9 random");
    end
    finish_run();
  end
endmodule